// File: doc/BRIEF.md
# Shifted-Subtract Accumulator with Status Flags

This block is a 32-bit accumulator execution unit. On a start strobe it takes a 16-bit operand, widens it to 32 bits (with sign or zero extension, depending on a mode input), and shifts it left. The shift amount is the low nibble of a separate shift-control register. It then subtracts the shifted value from the accumulator and writes the difference back. Each subtraction updates four status flags: zero, negative, carry (carry set means no borrow) and overflow. It also updates a small signed overflow counter. A saturation mode clamps an overflowing result to the most positive or most negative 32-bit value, and the counter is frozen while that mode is on.

A repeat count lets one start strobe run the same subtraction several times back to back, one per clock. The zero, negative and carry flags describe only the last pass. The overflow flag and the counter collect every overflow seen along the way. A one-cycle done strobe marks the final write. A load input sets the accumulator between operations. Operand fetch and instruction decode belong to the surrounding pipeline.

Top module: `shsub_acc_unit`

## Requirements
- R1: The shift amount is `shift_reg_i[3:0]` (0 to 15). Bits 15:4 of `shift_reg_i` have no effect on any result.
- R2: The operand is extended to 32 bits before shifting: sign-extended when `sext_i`=1 and zero-extended when `sext_i`=0. The low bits are zero-filled, and bits shifted beyond bit 31 are lost.
- R3: Each pass writes `acc_o - value` (modulo 2^32) to `acc_o`. When the unit is idle and `start_i`=0, `load_i`=1 sets `acc_o` to `load_val_i` on the next edge.
- R4: After each pass, `flag_z_o`=1 exactly when `acc_o` is zero, and `flag_n_o` equals `acc_o[31]`.
- R5: `flag_c_o` is 0 when the pass borrows (the unsigned accumulator is below the unsigned value) and 1 otherwise.
- R6: A pass that overflows sets `flag_v_o`. No pass clears it; only reset does. A positive overflow is a non-negative accumulator minus a negative value giving a negative result. A negative overflow is a negative accumulator minus a non-negative value giving a non-negative result.
- R7: With `sat_i`=0, `ovc_o` (6-bit two's complement, wrapping modulo 64) goes up by 1 on a positive overflow and down by 1 on a negative overflow. With `sat_i`=1 it is unchanged.
- R8: With `sat_i`=1, an overflowing pass writes 0x7FFFFFFF on a positive overflow and 0x80000000 on a negative overflow. The flags are then taken from the clamped value, and carry from the raw subtraction.
- R9: A start with `rep_i`=N runs N+1 passes on consecutive clocks. `done_o` is high for exactly one cycle, in the cycle after the final write. `operand_i`, `shift_reg_i`, `sext_i`, `sat_i` and `rep_i` are sampled only on the accepted start edge.
- R10: Reset clears `acc_o`, every flag, `ovc_o`, `busy_o` and `done_o`. While `busy_o`=1, `start_i` and `load_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| operand_i | input | 16 | Operand to shift and subtract |
| shift_reg_i | input | 16 | Shift-control register; low nibble is the shift |
| sext_i | input | 1 | 1: sign-extend operand, 0: zero-extend |
| sat_i | input | 1 | 1: saturate on overflow and freeze counter |
| rep_i | input | 8 | Repeat count N (N+1 passes) |
| load_i | input | 1 | Load accumulator when idle |
| load_val_i | input | 32 | Value for accumulator load |
| acc_o | output | 32 | Accumulator |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_c_o | output | 1 | Carry flag (1 = no borrow) |
| flag_v_o | output | 1 | Sticky overflow flag |
| ovc_o | output | 6 | Signed overflow counter |
| busy_o | output | 1 | Passes in progress |
| done_o | output | 1 | One-cycle pulse after the final pass |

## Verification
The hardest case to reach from the ports is an overflow in a middle pass of a repeated run that later passes move away from. In that case only the sticky overflow flag and the counter remember it. The stimulus loads the accumulator close to a signed limit and applies a large shifted operand of the right sign with a repeat count above zero. Further passes then either wrap through the limit several times or stay clamped. Random runs aim their accumulator values at both limits so that this happens often, and the counter is driven through its wrap at the 6-bit boundary.

// File: rtl/shsub_pkg.sv
package shsub_pkg;
  localparam int ACC_W    = 32;
  localparam int OP_W     = 16;
  localparam int SH_SEL_W = 4;

  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  typedef struct packed {
    logic [ACC_W-1:0] res;
    logic             borrow;
    logic             ovf_pos;
    logic             ovf_neg;
  } sub_res_t;

  // Extend operand to accumulator width, then shift left with zero fill.
  function automatic logic [ACC_W-1:0] prep_operand(
    input logic [OP_W-1:0]     op,
    input logic [SH_SEL_W-1:0] sh,
    input logic                sext
  );
    logic [ACC_W-1:0] ext;
    ext = sext ? {{(ACC_W-OP_W){op[OP_W-1]}}, op}
               : {{(ACC_W-OP_W){1'b0}}, op};
    return ext << sh;
  endfunction

  // One subtraction pass with borrow, overflow direction and clamping.
  function automatic sub_res_t sub_step(
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] val,
    input logic             sat
  );
    sub_res_t r;
    logic [ACC_W:0] wide;
    wide      = {1'b0, acc} - {1'b0, val};
    r.borrow  = wide[ACC_W];
    r.ovf_pos = ~acc[ACC_W-1] &  val[ACC_W-1] &  wide[ACC_W-1];
    r.ovf_neg =  acc[ACC_W-1] & ~val[ACC_W-1] & ~wide[ACC_W-1];
    if (sat && r.ovf_pos)      r.res = ACC_MAX;
    else if (sat && r.ovf_neg) r.res = ACC_MIN;
    else                       r.res = wide[ACC_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/shsub_operand_prep.sv
module shsub_operand_prep
  import shsub_pkg::*;
(
  input  logic [OP_W-1:0]     op_i,
  input  logic [SH_SEL_W-1:0] sh_i,
  input  logic                sext_i,
  output logic [ACC_W-1:0]    val_o
);
  always_comb val_o = prep_operand(op_i, sh_i, sext_i);
endmodule

// File: rtl/shsub_sub_alu.sv
module shsub_sub_alu
  import shsub_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] val_i,
  input  logic             sat_i,
  output logic [ACC_W-1:0] res_o,
  output logic             borrow_o,
  output logic             ovf_pos_o,
  output logic             ovf_neg_o
);
  sub_res_t r;
  always_comb begin
    r         = sub_step(acc_i, val_i, sat_i);
    res_o     = r.res;
    borrow_o  = r.borrow;
    ovf_pos_o = r.ovf_pos;
    ovf_neg_o = r.ovf_neg;
  end
endmodule

// File: rtl/shsub_repeat_ctrl.sv
module shsub_repeat_ctrl #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [REP_W-1:0] rep_i,
  output logic             start_ok_o,
  output logic             step_o,
  output logic             last_o,
  output logic             busy_o
);
  logic [REP_W-1:0] remain_q;

  assign start_ok_o = start_i & ~busy_o;
  assign step_o     = busy_o;
  assign last_o     = busy_o & (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      remain_q <= '0;
    end else if (start_ok_o) begin
      busy_o   <= 1'b1;
      remain_q <= rep_i;
    end else if (last_o) begin
      busy_o   <= 1'b0;
    end else if (step_o) begin
      remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/shsub_acc_unit.sv
module shsub_acc_unit
  import shsub_pkg::*;
#(
  parameter int REP_W   = 8,
  parameter int OVC_W   = 6,
  parameter int SHREG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [OP_W-1:0]    operand_i,
  input  logic [SHREG_W-1:0] shift_reg_i,
  input  logic               sext_i,
  input  logic               sat_i,
  input  logic [REP_W-1:0]   rep_i,
  input  logic               load_i,
  input  logic [ACC_W-1:0]   load_val_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic               flag_z_o,
  output logic               flag_n_o,
  output logic               flag_c_o,
  output logic               flag_v_o,
  output logic [OVC_W-1:0]   ovc_o,
  output logic               busy_o,
  output logic               done_o
);
  // Named internal events, brought out for the bound checker.
  logic             start_ok, step_en, last_step, load_ok;
  logic [ACC_W-1:0] prep_val, val_q, alu_res;
  logic             sat_q, alu_borrow, ovf_pos, ovf_neg;

  shsub_repeat_ctrl #(.REP_W(REP_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rep_i      (rep_i),
    .start_ok_o (start_ok),
    .step_o     (step_en),
    .last_o     (last_step),
    .busy_o     (busy_o)
  );

  shsub_operand_prep u_prep (
    .op_i   (operand_i),
    .sh_i   (shift_reg_i[SH_SEL_W-1:0]),
    .sext_i (sext_i),
    .val_o  (prep_val)
  );

  shsub_sub_alu u_alu (
    .acc_i     (acc_o),
    .val_i     (val_q),
    .sat_i     (sat_q),
    .res_o     (alu_res),
    .borrow_o  (alu_borrow),
    .ovf_pos_o (ovf_pos),
    .ovf_neg_o (ovf_neg)
  );

  assign load_ok = load_i & ~busy_o & ~start_i;

  // Operation latch: sampled only on an accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      sat_q <= 1'b0;
    end else if (start_ok) begin
      val_q <= prep_val;
      sat_q <= sat_i;
    end
  end

  // Accumulator and flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o    <= '0;
      flag_z_o <= 1'b0;
      flag_n_o <= 1'b0;
      flag_c_o <= 1'b0;
      flag_v_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= step_en & last_step;
      if (step_en) begin
        acc_o    <= alu_res;
        flag_z_o <= (alu_res == '0);
        flag_n_o <= alu_res[ACC_W-1];
        flag_c_o <= ~alu_borrow;
        flag_v_o <= flag_v_o | ovf_pos | ovf_neg;
      end else if (load_ok) begin
        acc_o <= load_val_i;
      end
    end
  end

  // Overflow counter: counts by direction, frozen in saturation mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovc_o <= '0;
    end else if (step_en && !sat_q) begin
      if (ovf_pos)      ovc_o <= ovc_o + 1'b1;
      else if (ovf_neg) ovc_o <= ovc_o - 1'b1;
    end
  end
endmodule

// File: rtl/shsub_acc_checker.sv
module shsub_acc_checker
  import shsub_pkg::*;
#(
  parameter int OVC_W   = 6,
  parameter int SHREG_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [OP_W-1:0]    operand_i,
  input logic [SHREG_W-1:0] shift_reg_i,
  input logic               sext_i,
  input logic               start_ok,
  input logic               step_en,
  input logic               sat_q,
  input logic [ACC_W-1:0]   val_q,
  input logic               ovf_pos,
  input logic               ovf_neg,
  input logic [ACC_W-1:0]   acc_o,
  input logic               flag_z_o,
  input logic               flag_n_o,
  input logic               flag_v_o,
  input logic [OVC_W-1:0]   ovc_o,
  input logic               busy_o,
  input logic               done_o
);
  // R1: upper shift-register bits set, nibble zero -> operand only extended
  a_r1_high_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && shift_reg_i[SH_SEL_W-1:0] == '0 && shift_reg_i[SHREG_W-1:SH_SEL_W] != '0)
    |=> val_q == ($past(sext_i) ? {{(ACC_W-OP_W){$past(operand_i[OP_W-1])}}, $past(operand_i)}
                                : {{(ACC_W-OP_W){1'b0}}, $past(operand_i)}));

  // R4
  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_z_o == (acc_o == '0)));
  a_r4_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_n_o == acc_o[ACC_W-1]));

  // R6
  a_r6_v_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_v_o |=> flag_v_o);
  a_r6_v_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (ovf_pos || ovf_neg)) |=> flag_v_o);

  // R7
  a_r7_ovc_frozen_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sat_q) |=> $stable(ovc_o));
  a_r7_ovc_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !sat_q && ovf_pos) |=> ovc_o == $past(ovc_o) + 1'b1);
  a_r7_ovc_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !sat_q && ovf_neg) |=> ovc_o == $past(ovc_o) - 1'b1);

  // R8
  a_r8_clamp_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sat_q && ovf_pos) |=> acc_o == ACC_MAX);
  a_r8_clamp_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sat_q && ovf_neg) |=> acc_o == ACC_MIN);

  // R9
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10
  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !start_ok);
endmodule

bind shsub_acc_unit shsub_acc_checker #(.OVC_W(OVC_W), .SHREG_W(SHREG_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .operand_i   (operand_i),
  .shift_reg_i (shift_reg_i),
  .sext_i      (sext_i),
  .start_ok    (start_ok),
  .step_en     (step_en),
  .sat_q       (sat_q),
  .val_q       (val_q),
  .ovf_pos     (ovf_pos),
  .ovf_neg     (ovf_neg),
  .acc_o       (acc_o),
  .flag_z_o    (flag_z_o),
  .flag_n_o    (flag_n_o),
  .flag_v_o    (flag_v_o),
  .ovc_o       (ovc_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/test_shsub_acc_unit.sv
module test_shsub_acc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] operand_i = '0;
  logic [15:0] shift_reg_i = '0;
  logic        sext_i = 1'b0;
  logic        sat_i = 1'b0;
  logic [7:0]  rep_i = '0;
  logic        load_i = 1'b0;
  logic [31:0] load_val_i = '0;
  logic [31:0] acc_o;
  logic        flag_z_o, flag_n_o, flag_c_o, flag_v_o, busy_o, done_o;
  logic [5:0]  ovc_o;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench reference state
  logic [31:0] m_acc = '0;
  bit m_z = 0, m_n = 0, m_c = 0, m_v = 0;
  int m_ovc = 0;

  always #10 clk = ~clk;  // 50 MHz

  shsub_acc_unit i_shsub_acc_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
    .shift_reg_i(shift_reg_i), .sext_i(sext_i), .sat_i(sat_i), .rep_i(rep_i),
    .load_i(load_i), .load_val_i(load_val_i), .acc_o(acc_o),
    .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_c_o(flag_c_o),
    .flag_v_o(flag_v_o), .ovc_o(ovc_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_prep(input logic [15:0] op, input logic [15:0] sh, input bit sx);
    longint e;
    e = sx ? longint'($signed(op)) : longint'(op);
    e = e << (sh % 16);
    return e[31:0];
  endfunction

  function automatic void m_step(input logic [31:0] val, input bit st);
    longint d;
    bit pos, neg;
    d   = longint'($signed(m_acc)) - longint'($signed(val));
    pos = d > 64'sd2147483647;
    neg = d < -64'sd2147483648;
    m_c = (m_acc >= val);
    if (pos || neg) m_v = 1;
    if (!st && pos) m_ovc = (m_ovc + 1) % 64;
    if (!st && neg) m_ovc = (m_ovc + 63) % 64;
    if (st && pos)      m_acc = 32'h7FFF_FFFF;
    else if (st && neg) m_acc = 32'h8000_0000;
    else                m_acc = d[31:0];
    m_z = (m_acc == 0);
    m_n = m_acc[31];
  endfunction

  task automatic do_load(input logic [31:0] v);
    @(negedge clk);
    load_i = 1'b1; load_val_i = v;
    @(negedge clk);
    load_i = 1'b0;
    m_acc = v;
    check("R3 load", acc_o, v);
  endtask

  task automatic check_state(input string tag);
    check({tag, " R3 acc"}, acc_o, m_acc);
    check({tag, " R4 z"}, 32'(flag_z_o), 32'(m_z));
    check({tag, " R4 n"}, 32'(flag_n_o), 32'(m_n));
    check({tag, " R5 c"}, 32'(flag_c_o), 32'(m_c));
    check({tag, " R6 v"}, 32'(flag_v_o), 32'(m_v));
    check({tag, " R7 ovc"}, 32'(ovc_o), 32'(m_ovc));
  endtask

  task automatic run_op(input logic [15:0] op, input logic [15:0] sh, input bit sx,
                        input bit st, input int rep, input string tag);
    int cyc;
    logic [31:0] val;
    @(negedge clk);
    operand_i = op; shift_reg_i = sh; sext_i = sx; sat_i = st;
    rep_i = 8'(rep); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // Scramble sampled inputs: R9 says they only matter at the start edge.
    operand_i = ~op; shift_reg_i = sh + 16'd5; sext_i = ~sx; sat_i = ~st; rep_i = 8'(rep + 3);
    cyc = 0;
    while (!done_o && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    val = m_prep(op, sh, sx);
    for (int i = 0; i <= rep; i++) m_step(val, st);
    check({tag, " R9 cycles"}, 32'(cyc), 32'(rep + 1));
    check_state(tag);
    @(negedge clk);
    check({tag, " R9 done one cycle"}, 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset acc", acc_o, 32'd0);
    check("R10 reset flags", {26'd0, flag_z_o, flag_n_o, flag_c_o, flag_v_o, busy_o, done_o}, 32'd0);
    check("R10 reset ovc", 32'(ovc_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: upper shift bits ignored, 0x100 - (1<<3) = 0xF8
    do_load(32'h100);
    run_op(16'h0001, 16'hFFF3, 1'b0, 1'b0, 0, "R1 nibble");
    check("R1 explicit", acc_o, 32'h0000_00F8);
    // R1 with zero nibble and high bits set
    do_load(32'h10);
    run_op(16'h0003, 16'hABC0, 1'b1, 1'b0, 0, "R1 zero shift");
    check("R1 zero shift explicit", acc_o, 32'h0000_000D);

    // R2 sign vs zero extension
    do_load(32'h0);
    run_op(16'h8000, 16'h0004, 1'b1, 1'b0, 0, "R2 sext");
    check("R2 sext explicit", acc_o, 32'h0008_0000);
    check("R5 borrow clears c", 32'(flag_c_o), 32'd0);
    do_load(32'h0);
    run_op(16'h8000, 16'h0004, 1'b0, 1'b0, 0, "R2 zext");
    check("R2 zext explicit", acc_o, 32'hFFF8_0000);
    do_load(32'h7FFF_8000);
    run_op(16'hFFFF, 16'h000F, 1'b0, 1'b0, 0, "R2 shift out");
    check("R2 shift out explicit", acc_o, 32'h0);
    check("R4 zero explicit", 32'(flag_z_o), 32'd1);
    check("R5 no borrow sets c", 32'(flag_c_o), 32'd1);

    // R8 saturation clamps, counter frozen
    do_load(32'h7FFF_FFFF);
    run_op(16'h8000, 16'h0000, 1'b1, 1'b1, 0, "R8 pos clamp");
    check("R8 pos explicit", acc_o, 32'h7FFF_FFFF);
    check("R7 frozen under sat", 32'(ovc_o), 32'd0);
    do_load(32'h8000_0000);
    run_op(16'h0001, 16'h0000, 1'b0, 1'b1, 2, "R8 neg clamp");
    check("R8 neg explicit", acc_o, 32'h8000_0000);

    // R7 counting both ways and wrap
    do_load(32'h8000_0000);
    run_op(16'h0001, 16'h0000, 1'b0, 1'b0, 0, "R7 neg");
    check("R7 wrap below zero", 32'(ovc_o), 32'd63);
    do_load(32'h7FFF_FFFF);
    run_op(16'h8000, 16'h000F, 1'b1, 1'b0, 0, "R7 pos");
    check("R7 back to zero", 32'(ovc_o), 32'd0);

    // R6 sticky V across a clean op
    do_load(32'h1000);
    run_op(16'h0001, 16'h0000, 1'b0, 1'b0, 0, "R6 sticky");
    check("R6 v stays", 32'(flag_v_o), 32'd1);

    // R9 repeat: intermediate overflows gathered, flags from last pass
    do_load(32'd10);
    run_op(16'h0003, 16'h0000, 1'b0, 1'b0, 3, "R9 repeat");
    check("R9 repeat explicit", acc_o, 32'hFFFF_FFFE);
    do_load(32'h7FFF_0000);
    run_op(16'hC000, 16'h000E, 1'b1, 1'b0, 6, "R9 multi ovf");

    // R10 start and load ignored while busy
    do_load(32'd1000);
    @(negedge clk);
    operand_i = 16'd1; shift_reg_i = 16'd0; sext_i = 0; sat_i = 0; rep_i = 8'd5; start_i = 1;
    @(negedge clk);
    start_i = 0;
    @(negedge clk);
    start_i = 1; operand_i = 16'd100; rep_i = 8'd0; load_i = 1; load_val_i = 32'h1234;
    @(negedge clk);
    start_i = 0; load_i = 0;
    while (!done_o) @(negedge clk);
    for (int i = 0; i < 6; i++) m_step(32'd1, 1'b0);
    check_state("R10 busy ignore");
    check("R10 busy ignore explicit", acc_o, 32'd994);
    @(negedge clk);
    check("R10 no late start", 32'(busy_o), 32'd0);

    // Random mix aimed at the signed limits
    for (int t = 0; t < 250; t++) begin
      logic [31:0] a;
      int rep;
      case ($urandom % 3)
        0: a = $urandom;
        1: a = {16'h7FFF, 16'($urandom)};
        default: a = {16'h8000, 16'($urandom)};
      endcase
      rep = ($urandom % 8 == 0) ? int'($urandom % 40) : int'($urandom % 4);
      do_load(a);
      run_op(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), rep, "R3 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule